// File: doc/BRIEF.md
# Wakeup Event Status Controller

A single 32-bit power-management register that records why the chip woke up or left reset. Seven event sources (a hot-sync pin, loss of the power adaptor, an RTC alarm, a modem ring line, an active-low wakeup pin, a watchdog reset and an active-low warm-reset pin) each latch a sticky flag. Software clears a flag by writing one to it. A power-on flag records a cold start. Three PLL lock lines are read back live.

Five of the sources have an enable bit each. The interrupt output is a level: it stays high while any enabled source has its flag set. Software can also request a warm reset by writing one to the top control bit, which drives an active-low reset request for a fixed number of clocks. All event inputs are treated as asynchronous and pass through two-flop synchronizers. The adaptor, ring and warm-reset inputs are also filtered, so they must hold a new level for `DEB_CYCLES` clocks before it counts. Only `por_n` clears the register, so the flags survive the warm reset that the block itself requests.

Top module: `wake_status_ctrl`

## Requirements
- R1: After `por_n` is released, `rdata` reads 0x00000001 when the PLL lock inputs are low, `irq` is low and `rst_req_n` is high.
- R2: A write with bit 16 set drives `rst_req_n` low for exactly `RST_LEN` (default 8) cycles, starting in the cycle after the write. A write with bit 16 clear leaves it high. Bit 16 always reads 0.
- R3: An event flag stays set until a write puts a 1 in its bit position. Writing 0 leaves the flag unchanged.
- R4: Bits 15..11 are read/write enables, in this order: hot-sync, adaptor, RTC, ring, wakeup pin. A write replaces all five.
- R5: `irq` is high exactly when some enabled source has its flag set. This includes the case where the enable is written after the flag was already set.
- R6: The flags sit at these bit positions: hot-sync rising edge at bit 10, watchdog rising edge at bit 9, `warm_n` falling edge at bit 8, `adp_ok` falling edge at bit 7, RTC alarm rising edge at bit 6, ring rising edge at bit 5, `wake_n` falling edge at bit 4.
- R7: The warm-reset, adaptor and ring inputs must hold their asserted level for `DEB_CYCLES` (default 16) synchronized clocks before the flag sets. A shorter glitch sets nothing.
- R8: When an event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R9: Bits 3..1 show `pll_lock[2:0]` two clocks after a change. Writes to these bits and to bits 31..17 are ignored, and bits 31..17 read 0.
- R10: Bit 0 is set by power-on reset and cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| wr | input | 1 | Write strobe for the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current register contents |
| hotsync | input | 1 | Hot-sync pin, active high |
| adp_ok | input | 1 | Power adaptor good; low means power failure |
| rtc_alarm | input | 1 | RTC wake alarm, active high |
| ring | input | 1 | Modem ring indicator, active high |
| wake_n | input | 1 | Wakeup pin, active low |
| wdt_rst | input | 1 | Watchdog reset indication, active high |
| warm_n | input | 1 | Warm-reset pin, active low |
| pll_lock | input | 3 | Lock status of three PLLs |
| irq | output | 1 | Level-sensitive interrupt request |
| rst_req_n | output | 1 | Active-low warm reset request |

## Verification
The bench aims at the cases a careless design gets wrong. A glitch shorter than the filter window must not set a flag; a design that skipped the filter would latch it. An event that arrives in the same cycle as a clear must survive; a design where the clear wins would lose the wake cause. An enable written after its flag is already set must still raise the interrupt; an edge-triggered interrupt would stay low. The warm-reset pulse is counted to the exact cycle, and random writes to the PLL, reserved and enable fields check that read-only bits never move and that the interrupt tracks a model of the enables and flags.

// File: rtl/wake_status_ctrl.sv
module wake_status_ctrl #(
  parameter int DEB_CYCLES = 16,
  parameter int RST_LEN    = 8
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        hotsync,
  input  logic        adp_ok,
  input  logic        rtc_alarm,
  input  logic        ring,
  input  logic        wake_n,
  input  logic        wdt_rst,
  input  logic        warm_n,
  input  logic [2:0]  pll_lock,
  output logic        irq,
  output logic        rst_req_n
);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [6:0] FILTERED = 7'b0011010;

  logic [9:0] s1, s2;
  logic [6:0] cond, prev, set, clr, ev;
  logic [4:0] en;
  logic       por_flag;
  logic [RW-1:0] rcnt;

  wire [9:0] raw = {pll_lock, hotsync, wdt_rst, ~warm_n, ~adp_ok, rtc_alarm, ring, ~wake_n};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar i = 0; i < 7; i++) begin : g_src
    if (FILTERED[i]) begin : g_deb
      logic [DW-1:0] cnt;
      logic          filt;
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) begin
          cnt  <= '0;
          filt <= 1'b0;
        end else if (s2[i] == filt) begin
          cnt <= '0;
        end else if (cnt == DW'(DEB_CYCLES - 1)) begin
          cnt  <= '0;
          filt <= s2[i];
        end else begin
          cnt <= cnt + 1'b1;
        end
      assign cond[i] = filt;
    end else begin : g_raw
      assign cond[i] = s2[i];
    end
  end

  assign set = cond & ~prev;
  assign clr = wr ? wdata[10:4] : 7'd0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      prev     <= '0;
      ev       <= '0;
      en       <= '0;
      por_flag <= 1'b1;
      rcnt     <= '0;
    end else begin
      prev <= cond;
      ev   <= (ev & ~clr) | set;
      if (wr) en <= wdata[15:11];
      if (wr && wdata[0]) por_flag <= 1'b0;
      if (wr && wdata[16]) rcnt <= RW'(RST_LEN);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
    end

  assign irq       = |(en & {ev[6], ev[3], ev[2], ev[1], ev[0]});
  assign rst_req_n = (rcnt == '0);
  assign rdata     = {15'd0, 1'b0, en, ev, s2[9:7], por_flag};

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !wr |=> ((rdata[10:4] & $past(rdata[10:4])) == $past(rdata[10:4])));
  a_r2_reset_pulse_starts: assert property (@(posedge clk) disable iff (!por_n)
    (wr && wdata[16]) |=> !rst_req_n);
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (rdata[15:11] != 5'd0));
  a_r4_enable_written: assert property (@(posedge clk) disable iff (!por_n)
    wr |=> (rdata[15:11] == $past(wdata[15:11])));
  a_r10_por_clears: assert property (@(posedge clk) disable iff (!por_n)
    (wr && wdata[0]) |=> !rdata[0]);
endmodule

// File: tb/wake_status_ctrl_bench.sv
module wake_status_ctrl_bench;
  logic clk = 0, por_n = 0, wr = 0;
  logic [31:0] wdata = 0, rdata;
  logic hotsync = 0, adp_ok = 1, rtc_alarm = 0, ring = 0, wake_n = 1, wdt_rst = 0, warm_n = 1;
  logic [2:0] pll_lock = 0;
  logic irq, rst_req_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wake_status_ctrl u_wake_status_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [31:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic drive(int i, bit act);
    case (i)
      0: hotsync = act;
      1: wdt_rst = act;
      2: warm_n = !act;
      3: adp_ok = !act;
      4: rtc_alarm = act;
      5: ring = act;
      default: wake_n = !act;
    endcase
  endtask

  task automatic fire(int i, int len);
    @(negedge clk); drive(i, 1);
    repeat (len) @(negedge clk);
    drive(i, 0);
    repeat (40) @(negedge clk);
  endtask

  function automatic bit irq_model(logic [4:0] e, logic [6:0] f);
    return |(e & {f[6], f[3], f[2], f[1], f[0]});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] en_m;
    logic [6:0] ev_m;
    int low;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk("R1 rdata", rdata, 32'h1);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req_n", rst_req_n, 1);

    wr_reg(32'h1);
    chk("R10 por clear", rdata, 32'h0);

    for (int i = 0; i < 7; i++) begin
      fire(i, 30);
      chk("R6 flag position", rdata[10:4], 7'h40 >> i);
      wr_reg(32'h400 >> i);
      chk("R3 w1c clears", rdata[10:4], 0);
    end

    fire(2, 5); fire(3, 5); fire(5, 5);
    chk("R7 glitch ignored", rdata[10:4], 0);

    fire(4, 3);
    wr_reg(32'h0);
    chk("R3 write zero keeps", rdata[10:4], 7'h04);
    wr_reg(32'h0000_0200);
    chk("R3 other clear keeps", rdata[10:4], 7'h04);

    @(negedge clk); rtc_alarm = 1;
    @(negedge clk);
    @(negedge clk);
    wr = 1; wdata = 32'h40;
    @(negedge clk); wr = 0; wdata = 0;
    chk("R8 set wins", rdata[6], 1);
    rtc_alarm = 0;
    repeat (5) @(negedge clk);
    wr_reg(32'h40);
    chk("R3 cleared", rdata[10:4], 0);

    fire(5, 30);
    chk("R5 masked irq", irq, 0);
    wr_reg(32'h1000);
    chk("R5 late enable irq", irq, 1);
    chk("R4 enable readback", rdata[15:11], 5'b00010);
    wr_reg(32'h1020);
    chk("R5 irq drops", irq, 0);

    @(negedge clk); pll_lock = 3'b101;
    @(negedge clk); @(negedge clk);
    chk("R9 pll live", rdata[3:1], 3'b101);
    wr_reg(32'hFFFE_000E);
    chk("R9 reserved zero", rdata[31:16], 0);
    chk("R9 pll unchanged", rdata[3:1], 3'b101);

    wr_reg(32'h0);
    chk("R2 zero no reset", rst_req_n, 1);
    @(negedge clk); wr = 1; wdata = 32'h0001_0000;
    @(negedge clk); wr = 0; wdata = 0;
    chk("R2 bit16 reads 0", rdata[16], 0);
    low = 0;
    for (int k = 0; k < 12; k++) begin
      if (!rst_req_n) low++;
      @(negedge clk);
    end
    chk("R2 pulse length", low, 8);

    for (int i = 0; i < 7; i++) fire(i, 30);
    en_m = 0; ev_m = 7'h7F;
    chk("R6 all flags", rdata[10:4], ev_m);
    for (int n = 0; n < 150; n++) begin
      logic [31:0] d;
      d = $urandom & 32'hFFFE_FFFF;
      d[10:4] = d[10:4] & $urandom & $urandom & $urandom;
      wr_reg(d);
      en_m = d[15:11];
      ev_m = ev_m & ~d[10:4];
      chk("R4 enables", rdata[15:11], en_m);
      chk("R3 flags", rdata[10:4], ev_m);
      chk("R5 irq", irq, irq_model(en_m, ev_m));
      chk("R9 pll", rdata[3:1], 3'b101);
      if (ev_m == 0) begin
        for (int i = 0; i < 7; i++) fire(i, 30);
        ev_m = 7'h7F;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule